// File: doc/BRIEF.md
# Keyed Two-Stage Watchdog

This block is a watchdog timer driven by a single 32-bit control word. Software arms the watchdog with a write that sets a run command and a reload count. It keeps the watchdog alive with further writes. Once the watchdog is armed, each refresh must carry a 7-bit key that is the bitwise inverse of the key stored by the last accepted write. This keeps a stray store from feeding the timer.

The counter decrements on a slow tick-enable input. The divider that makes this tick lies outside the block. When the count first runs out, the block raises a non-maskable interrupt level and restarts the counter with a short grace count. This gives a handler time to respond. If the grace count also runs out with no accepted write in between, the block emits a one-cycle system reset request.

The stored control word and the live counter value are available for readback.

Top module: `keyed_watchdog`

## Requirements
- R1: After reset, the stored control word is 0, the counter reads 0 and is stopped, and `nmi` and `reset_req` are low.
- R2: While stored bit 8 is 0, a write is accepted whatever key it carries.
- R3: While stored bit 8 is 1, a write whose bits [15:9] differ from the bitwise inverse of the stored bits [15:9] is discarded. The stored word, the counter, the run state and `nmi` are all left unchanged.
- R4: An accepted write stores the whole word in the next cycle. It reloads the counter from bits [8:0]. The counter runs if bit 8 is 1 and stops if bit 8 is 0.
- R5: A count field of 0 reloads the counter with 256.
- R6: The counter drops by one on each cycle where `tick` is high and the counter is running. Otherwise it holds its value.
- R7: A tick that moves a running counter off the value 1 while `nmi` is low sets `nmi` high. The same tick reloads the counter with the grace count of 10, and the counter keeps running.
- R8: Such a tick while `nmi` is already high produces `reset_req` high for exactly one cycle. It also stops the counter at 0, and `nmi` stays high.
- R9: An accepted write clears `nmi` and the timeout history, so the next expiry again raises `nmi` first.
- R10: When an accepted write and an expiring tick fall in the same cycle, the write wins. The counter is reloaded, and neither `nmi` nor `reset_req` is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Decrement enable from the slow time base |
| wr_en | input | 1 | Control word write strobe |
| wr_data | input | 32 | Control word: [8:0] count, bit 8 run command, [15:9] key |
| ctrl_o | output | 32 | Stored control word |
| count_o | output | 9 | Current counter value |
| nmi | output | 1 | Non-maskable interrupt level after the first expiry |
| reset_req | output | 1 | One-cycle system reset request after the second expiry |

## Verification
A behavioural model is compared with the block on every clock. The tick pattern alternates between dense and sparse runs, so that a counter that ignores `tick` or decrements while stopped shows up at once.

The writes cover several cases:
- Writes while disarmed use arbitrary keys, which separates the armed and disarmed key rules.
- Writes with a repeated key and with a zero key check that rejection leaves every output untouched.
- A full expiry sequence shows the two-stage order and the single-cycle reset pulse.
- Writes that coincide with the last tick of the main count and of the grace count test write-over-expiry priority.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

    localparam int WORD_W  = 32;
    localparam int CNT_W   = 9;
    localparam int KEY_W   = 7;
    localparam int KEY_LSB = 9;
    localparam int CMD_BIT = 8;
    localparam int GRACE   = 10;

    // Key field of a control word
    function automatic logic [KEY_W-1:0] key_of(input logic [WORD_W-1:0] w);
        return w[KEY_LSB +: KEY_W];
    endfunction

    // Reload value taken from the count field; zero stands for 256
    function automatic logic [CNT_W-1:0] reload_of(input logic [WORD_W-1:0] w);
        logic [CNT_W-1:0] f;
        f = w[CNT_W-1:0];
        return (f == '0) ? CNT_W'(1 << (CNT_W-1)) : f;
    endfunction

endpackage

// File: rtl/wdt_keygate.sv
module wdt_keygate
    import wdt_pkg::*;
(
    input  logic              wr_en,
    input  logic [WORD_W-1:0] wr_data,
    input  logic [WORD_W-1:0] stored,
    output logic              accept
);
    logic armed;
    logic key_ok;

    always_comb begin
        armed  = stored[CMD_BIT];
        key_ok = (key_of(wr_data) == ~key_of(stored));
        accept = wr_en && (!armed || key_ok);
    end
endmodule

// File: rtl/wdt_countdown.sv
module wdt_countdown #(
    parameter int CNT_W = 9,
    parameter int GRACE = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             load,
    input  logic [CNT_W-1:0] load_cnt,
    input  logic             load_run,
    input  logic             nmi_q,
    output logic             expire,
    output logic [CNT_W-1:0] cnt_o,
    output logic             run_o
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             run;
    } cd_state_t;

    cd_state_t s_d, s_q;

    always_comb begin
        expire = tick && s_q.run && (s_q.cnt == CNT_W'(1));
        s_d    = s_q;
        if (load) begin
            s_d.cnt = load_cnt;
            s_d.run = load_run;
        end else if (expire) begin
            if (nmi_q) begin
                s_d.cnt = '0;
                s_d.run = 1'b0;
            end else begin
                s_d.cnt = CNT_W'(GRACE);
            end
        end else if (tick && s_q.run) begin
            s_d.cnt = s_q.cnt - CNT_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign cnt_o = s_q.cnt;
    assign run_o = s_q.run;

    // R6: no tick on a running counter and no load -> value holds
    a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !(tick && run_o)) |=> $stable(cnt_o));

    // R7: the first expiry reloads the grace count and keeps running
    a_r7_grace: assert property (@(posedge clk) disable iff (!rst_n)
        (expire && !nmi_q && !load) |=> (cnt_o == CNT_W'(GRACE) && run_o));

    // R8: the second expiry stops the counter
    a_r8_stop: assert property (@(posedge clk) disable iff (!rst_n)
        (expire && nmi_q && !load) |=> (!run_o && cnt_o == '0));
endmodule

// File: rtl/wdt_expiry.sv
module wdt_expiry (
    input  logic clk,
    input  logic rst_n,
    input  logic expire,
    input  logic accept,
    output logic nmi,
    output logic reset_req
);
    typedef struct packed {
        logic nmi;
        logic rreq;
    } ex_state_t;

    ex_state_t s_d, s_q;

    always_comb begin
        s_d.rreq = 1'b0;
        s_d.nmi  = s_q.nmi;
        if (accept) begin
            s_d.nmi = 1'b0;
        end else if (expire) begin
            if (s_q.nmi) s_d.rreq = 1'b1;
            else         s_d.nmi  = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign nmi       = s_q.nmi;
    assign reset_req = s_q.rreq;

    // R8: the reset request lasts one cycle
    a_r8_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        reset_req |=> !reset_req);

    // R8: a reset request only follows a raised NMI
    a_r8_after_nmi: assert property (@(posedge clk) disable iff (!rst_n)
        reset_req |-> nmi);

    // R9 and R10: an accepted write leaves no NMI and no reset request
    a_r9_clear: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> (!nmi && !reset_req));
endmodule

// File: rtl/keyed_watchdog.sv
module keyed_watchdog
    import wdt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              wr_en,
    input  logic [31:0]       wr_data,
    output logic [31:0]       ctrl_o,
    output logic [CNT_W-1:0]  count_o,
    output logic              nmi,
    output logic              reset_req
);
    typedef struct packed {
        logic [WORD_W-1:0] ctrl;
    } top_state_t;

    top_state_t s_d, s_q;
    logic       accept;
    logic       expire;
    logic       run;

    wdt_keygate u_gate (
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .stored  (s_q.ctrl),
        .accept  (accept)
    );

    wdt_countdown #(.CNT_W(CNT_W), .GRACE(GRACE)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .load     (accept),
        .load_cnt (reload_of(wr_data)),
        .load_run (wr_data[CMD_BIT]),
        .nmi_q    (nmi),
        .expire   (expire),
        .cnt_o    (count_o),
        .run_o    (run)
    );

    wdt_expiry u_exp (
        .clk       (clk),
        .rst_n     (rst_n),
        .expire    (expire),
        .accept    (accept),
        .nmi       (nmi),
        .reset_req (reset_req)
    );

    always_comb begin
        s_d = s_q;
        if (accept) s_d.ctrl = wr_data;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign ctrl_o = s_q.ctrl;

    // R3: a key mismatch while armed leaves the stored word alone
    a_r3_reject: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && ctrl_o[CMD_BIT] && (key_of(wr_data) != ~key_of(ctrl_o)))
        |=> $stable(ctrl_o));

    // R4: an accepted write is stored in the next cycle
    a_r4_store: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> (ctrl_o == $past(wr_data)));

    // R4: the run state follows the command bit of the stored word after a write
    a_r4_run: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> (run == ctrl_o[CMD_BIT]));
endmodule

// File: tb/sim_keyed_watchdog.sv
module sim_keyed_watchdog;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] ctrl_o;
    logic [8:0]  count_o;
    logic        nmi;
    logic        reset_req;

    always #4 clk = ~clk;

    keyed_watchdog u0 (
        .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en), .wr_data(wr_data),
        .ctrl_o(ctrl_o), .count_o(count_o), .nmi(nmi), .reset_req(reset_req)
    );

    int    checks = 0;
    int    fails  = 0;
    int    rr_seen = 0;
    string ph = "R1";

    // reference model state
    int m_ctrl = 0, m_cnt = 0, m_run = 0, m_nmi = 0, m_rr = 0;

    function automatic int mk(int key, int cmd, int lo);
        return ((key & 127) << 9) | ((cmd & 1) << 8) | (lo & 255);
    endfunction

    function automatic int good_key();
        return (~(m_ctrl >> 9)) & 127;
    endfunction

    task automatic chk(input string req, input bit ok, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic model(input bit t, input bit w, input int d);
        bit acc;
        int c;
        acc = w && (((m_ctrl >> 8) & 1) == 0 || ((d >> 9) & 127) == good_key());
        m_rr = 0;
        if (acc) begin
            m_ctrl = d;
            c = d & 511;
            m_cnt = (c == 0) ? 256 : c;
            m_run = (d >> 8) & 1;
            m_nmi = 0;
        end else if (t && m_run == 1) begin
            if (m_cnt == 1) begin
                if (m_nmi == 1) begin
                    m_rr = 1; m_run = 0; m_cnt = 0;
                end else begin
                    m_nmi = 1; m_cnt = 10;
                end
            end else m_cnt--;
        end
    endtask

    task automatic compare();
        chk({ph, " ctrl"},  ctrl_o == 32'(m_ctrl), int'(ctrl_o), m_ctrl);
        chk({ph, " count"}, count_o == 9'(m_cnt), int'(count_o), m_cnt);
        chk({ph, " nmi"},   nmi == 1'(m_nmi), int'(nmi), m_nmi);
        chk({ph, " rreq"},  reset_req == 1'(m_rr), int'(reset_req), m_rr);
        if (reset_req) rr_seen++;
    endtask

    task automatic cyc(input bit t, input bit w, input int d);
        tick = t; wr_en = w; wr_data = 32'(d);
        @(posedge clk);
        model(t, w, d);
        @(negedge clk);
        compare();
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++; checks++;
        $display("FAIL watchdog timeout actual=hung expected=done");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        ph = "R1";
        compare();
        for (int i = 0; i < 4; i++) cyc(1, 0, 0);

        ph = "R5";                       // disarmed, count 0 -> 256 stopped
        cyc(0, 1, mk(7'h33, 0, 0));
        ph = "R6";                       // stopped counter ignores ticks
        for (int i = 0; i < 6; i++) cyc(1, 0, 0);

        ph = "R2";                       // disarmed: any key accepted
        cyc(0, 1, mk(7'h15, 1, 5));
        ph = "R6";
        for (int i = 0; i < 24; i++) cyc((i % 3) != 1, 0, 0);

        ph = "R3";                       // armed: wrong keys discarded
        cyc(1, 1, mk(7'h15, 1, 9));
        cyc(0, 1, mk(7'h00, 0, 0));
        chk("R3 not stopped", count_o != 9'd256, int'(count_o), 0);

        ph = "R4";
        cyc(0, 1, mk(good_key(), 1, 3));
        chk("R4 reload", count_o == 9'd259, int'(count_o), 259);

        ph = "R7";
        for (int i = 0; i < 600 && m_nmi == 0; i++) cyc(1, 0, 0);
        chk("R7 grace", count_o == 9'd10 && nmi, int'(count_o), 10);

        ph = "R8";
        for (int i = 0; i < 14; i++) cyc(i % 2 == 0 || i > 6, 0, 0);
        chk("R8 single pulse", rr_seen == 1, rr_seen, 1);

        ph = "R9";
        cyc(0, 1, mk(good_key(), 1, 2));
        chk("R9 nmi cleared", !nmi, int'(nmi), 0);
        for (int i = 0; i < 600 && m_nmi == 0; i++) cyc(1, 0, 0);
        chk("R9 nmi again first", nmi && rr_seen == 1, rr_seen, 1);

        ph = "R10";                       // write on the last grace tick
        for (int i = 0; i < 20 && m_cnt > 1; i++) cyc(1, 0, 0);
        cyc(1, 1, mk(good_key(), 1, 0));
        chk("R10 no reset", rr_seen == 1 && !nmi, rr_seen, 1);
        for (int i = 0; i < 600 && m_cnt > 1; i++) cyc(1, 0, 0);
        cyc(1, 1, mk(good_key(), 1, 4)); // write on the last main tick
        chk("R10 no nmi", !nmi && count_o == 9'd260, int'(count_o), 260);

        ph = "R4";                       // stop command with correct key
        cyc(0, 1, mk(good_key(), 0, 7));
        ph = "R6";
        for (int i = 0; i < 8; i++) cyc(1, 0, 0);
        ph = "R2";
        cyc(0, 1, mk(7'h7F, 0, 1));

        finish_run();
    end
endmodule